// File: doc/BRIEF.md
# Frame Sync Period Validator

This block sits in the reference clock domain and watches a frame sync input that is generated from that same clock. It counts reference cycles between successive active edges of the sync. When a period holds exactly the nominal count for an 8 kHz or a 2 kHz frame, the sync is accepted. The block then raises a valid flag, reports which of the two rates was seen, and emits a one-cycle strobe. The strobe marks the reference edge that lags the sync edge, which is the point downstream frame pulses align to.

Nominal counts are derived from the reference frequency parameter. For 8.192 MHz they are 1024 cycles at 8 kHz and 4096 cycles at 2 kHz. One wrong period withdraws the flag at once. One correct period restores it. A sync that stops arriving is withdrawn as soon as the counter passes the longest nominal count. A run-time inversion control allows an active-low frame pulse to be used directly.

Top module: `fsv_frame_validator`

## Requirements
- R1: While reset is low and on the first cycle after it, `frame_valid`, `frame_rate` and `frame_stb` are all 0.
- R2: A frame edge is a 0-to-1 change of the sync level after optional inversion, sampled on `clk_ref`. The first frame edge after reset never sets `frame_valid` or `frame_stb`, because it has no earlier edge to measure from. A sync held at its active level produces no further edges.
- R3: With the default single sampling stage, each frame edge is judged at the second rising clock edge after the sync is first sampled active. If the cycle count from the previous frame edge equals REF_HZ/8000, then from that clock edge `frame_valid` is 1 and `frame_rate` is 0 (0 encodes 8 kHz).
- R4: If the measured count equals REF_HZ/2000, then `frame_valid` is 1 and `frame_rate` is 1 (1 encodes 2 kHz).
- R5: Any other count sets `frame_valid` to 0 and gives no strobe. `frame_rate` keeps its previous value whenever a period is rejected.
- R6: When REF_HZ/2000+1 cycles pass with no frame edge, `frame_valid` drops. Counting from the clock edge that judged the last frame, it drops at the (REF_HZ/2000+1)-th rising clock edge. The counter then holds its saturated value until the next edge.
- R7: After any rejection or timeout, a single period with a nominal count sets `frame_valid` again.
- R8: When `sync_invert` is 1, a high-to-low transition on `sync_in` is the frame edge. Periods are measured between such falling transitions.
- R9: `frame_stb` is high for exactly one cycle for each accepted frame edge. It is 0 on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Frame sync derived from the reference clock |
| sync_invert | input | 1 | 1 treats `sync_in` as active low |
| frame_valid | output | 1 | Last measured period matched a nominal count |
| frame_rate | output | 1 | Rate of the last accepted period: 0 = 8 kHz, 1 = 2 kHz |
| frame_stb | output | 1 | One-cycle strobe at the aligned boundary of an accepted frame |

## Verification
The in-line assertions check several rules on every cycle. A rejected count always clears the flag without a strobe. The rate holds between frame edges. The counter stays saturated until an edge arrives. A rising valid flag always comes with a strobe. Two strobes never occur back to back.

Other behaviour can only be shown by driving the block from outside. The bench scenarios exercise the exact nominal counts and their one-off neighbours, the ignored first edge after reset, and timeout in the middle of a period. They also cover recovery after a bad period and the active-low input mode. Each is compared against a period-by-period model kept in the bench.

// File: rtl/fsv_pkg.sv
package fsv_pkg;
   typedef enum logic {
      RATE_8K = 1'b0,
      RATE_2K = 1'b1
   } fsv_rate_e;

   function automatic int fsv_nominal(input int ref_hz, input int frame_hz);
      return ref_hz / frame_hz;
   endfunction
endpackage

// File: rtl/fsv_sync_edge.sv
module fsv_sync_edge #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_pin,
   input  logic invert,
   output logic edge_o
);
   logic level_in;
   logic level_s;
   logic level_d;

   assign level_in = sync_pin ^ invert;

   generate
      if (STAGES < 1) begin : g_bad
         $error("fsv_sync_edge: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= level_in;
         end
         assign level_s = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] s_q;
         always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[STAGES-2:0], level_in};
         end
         assign level_s = s_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level_s;
   end

   assign edge_o = level_s & ~level_d;

   // R2: an edge needs a low sample in between, so edges never repeat on adjacent cycles
   assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);
endmodule

// File: rtl/fsv_period_cnt.sv
module fsv_period_cnt #(
   parameter int CW  = 13,
   parameter int SAT = 4097
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   output logic [CW-1:0] cnt_o,
   output logic          ovf_o
);
   localparam logic [CW-1:0] SAT_V = CW'(SAT);
   localparam logic [CW-1:0] ONE_V = CW'(1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart)        cnt_q <= ONE_V;
      else if (cnt_q != SAT_V) cnt_q <= cnt_q + ONE_V;
   end

   assign cnt_o = cnt_q;
   assign ovf_o = (cnt_q == SAT_V);

   // R6: once saturated, the count holds until an edge restarts it
   assert_cnt_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !restart) |=> ovf_o);
   // R3: every edge opens a new period at a count of one
   assert_cnt_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_o == ONE_V));
endmodule

// File: rtl/fsv_judge.sv
module fsv_judge
   import fsv_pkg::*;
#(
   parameter int CW = 13,
   parameter int N8 = 1024,
   parameter int N2 = 4096
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          edge_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          ovf_i,
   output logic          valid_o,
   output fsv_rate_e     rate_o,
   output logic          stb_o
);
   localparam logic [CW-1:0] N8_V = CW'(N8);
   localparam logic [CW-1:0] N2_V = CW'(N2);

   logic      have_prev_q;
   logic      valid_q;
   logic      stb_q;
   fsv_rate_e rate_q;
   logic      hit8;
   logic      hit2;

   assign hit8 = have_prev_q && (cnt_i == N8_V);
   assign hit2 = have_prev_q && (cnt_i == N2_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_prev_q <= 1'b0;
         valid_q     <= 1'b0;
         stb_q       <= 1'b0;
         rate_q      <= RATE_8K;
      end else begin
         stb_q <= 1'b0;
         if (edge_i) begin
            have_prev_q <= 1'b1;
            if (hit8) begin
               valid_q <= 1'b1;
               rate_q  <= RATE_8K;
               stb_q   <= 1'b1;
            end else if (hit2) begin
               valid_q <= 1'b1;
               rate_q  <= RATE_2K;
               stb_q   <= 1'b1;
            end else begin
               valid_q <= 1'b0;
            end
         end else if (ovf_i) begin
            valid_q <= 1'b0;
         end
      end
   end

   assign valid_o = valid_q;
   assign rate_o  = rate_q;
   assign stb_o   = stb_q;

   // R5: an off-nominal count withdraws the flag and gives no strobe
   assert_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && (cnt_i != N8_V) && (cnt_i != N2_V)) |=> (!valid_o && !stb_o));
   // R5: the rate only changes when an edge is judged
   assert_rate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_i |=> $stable(rate_o));
   // R6: the counter running past the longest period clears the flag
   assert_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_i && !edge_i) |=> !valid_o);
   // R7: a rising flag is always accompanied by a boundary strobe
   assert_rise_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> stb_o);
   // R9: a strobe only follows a judged edge
   assert_stb_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |-> $past(edge_i));
endmodule

// File: rtl/fsv_frame_validator.sv
module fsv_frame_validator
   import fsv_pkg::*;
#(
   parameter int REF_HZ      = 8192000,
   parameter int SYNC_STAGES = 1
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic sync_in,
   input  logic sync_invert,
   output logic frame_valid,
   output logic frame_rate,
   output logic frame_stb
);
   localparam int N8  = fsv_nominal(REF_HZ, 8000);
   localparam int N2  = fsv_nominal(REF_HZ, 2000);
   localparam int SAT = N2 + 1;
   localparam int CW  = $clog2(SAT + 1);

   generate
      if ((REF_HZ % 8000) != 0) begin : g_chk_hz
         $error("fsv_frame_validator: REF_HZ must be a multiple of 8000");
      end
      if (N8 < 4) begin : g_chk_min
         $error("fsv_frame_validator: REF_HZ too low for period counting");
      end
   endgenerate

   logic          edge_w;
   logic [CW-1:0] cnt_w;
   logic          ovf_w;
   fsv_rate_e     rate_w;

   fsv_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .sync_pin (sync_in),
      .invert   (sync_invert),
      .edge_o   (edge_w)
   );

   fsv_period_cnt #(.CW(CW), .SAT(SAT)) u_cnt (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .restart (edge_w),
      .cnt_o   (cnt_w),
      .ovf_o   (ovf_w)
   );

   fsv_judge #(.CW(CW), .N8(N8), .N2(N2)) u_judge (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .edge_i  (edge_w),
      .cnt_i   (cnt_w),
      .ovf_i   (ovf_w),
      .valid_o (frame_valid),
      .rate_o  (rate_w),
      .stb_o   (frame_stb)
   );

   assign frame_rate = rate_w;

   // R9: two strobes are never adjacent
   assert_stb_pulse_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      frame_stb |=> !frame_stb);
   // R3: a strobe always comes with the valid flag
   assert_stb_valid_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      frame_stb |-> frame_valid);
   // R1: outputs leave reset cleared
   assert_reset_R1: assert property (@(posedge clk_ref)
      $rose(rst_n) |-> (!frame_valid && !frame_stb && !frame_rate));
endmodule

// File: tb/sim_fsv_frame_validator.sv
module sim_fsv_frame_validator;
   localparam int CLK_PERIOD = 10;
   localparam int REF_HZ = 256000;
   localparam int N8 = REF_HZ / 8000;
   localparam int N2 = REF_HZ / 2000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_in = 1'b0;
   logic sync_invert = 1'b0;
   logic frame_valid, frame_rate, frame_stb;

   int checks = 0;
   int errors = 0;
   logic m_have_prev, m_valid, m_rate;
   int last_gap;

   always #(CLK_PERIOD/2) clk = ~clk;

   fsv_frame_validator #(.REF_HZ(REF_HZ), .SYNC_STAGES(1)) u0 (
      .clk_ref(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_invert(sync_invert),
      .frame_valid(frame_valid), .frame_rate(frame_rate), .frame_stb(frame_stb)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic hit(input int gap);
      return (gap == N8) || (gap == N2);
   endfunction

   task automatic drive_level(input logic active);
      sync_in = active ^ sync_invert;
   endtask

   task automatic do_reset(input logic inv);
      @(negedge clk);
      rst_n = 1'b0;
      sync_invert = inv;
      drive_level(1'b0);
      repeat (3) @(negedge clk);
      chk("R1 valid", frame_valid, 0);
      chk("R1 stb", frame_stb, 0);
      chk("R1 rate", frame_rate, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after release", frame_valid, 0);
      m_have_prev = 1'b0;
      m_valid = 1'b0;
      m_rate = 1'b0;
      last_gap = 0;
   endtask

   // one frame edge now, followed by a gap of 'gap' cycles to the next edge
   task automatic frame(input int gap, input string tag);
      logic exp_stb;
      drive_level(1'b1);
      @(negedge clk);
      drive_level(1'b0);
      @(negedge clk);
      exp_stb = 1'b0;
      if (m_have_prev) begin
         if (hit(last_gap)) begin
            m_valid = 1'b1;
            m_rate = (last_gap == N2);
            exp_stb = 1'b1;
         end else begin
            m_valid = 1'b0;
         end
      end
      m_have_prev = 1'b1;
      chk({tag, " valid"}, frame_valid, m_valid);
      chk({tag, " rate"}, frame_rate, m_rate);
      chk({tag, " stb"}, frame_stb, exp_stb);
      repeat (gap - 2) @(negedge clk);
      if (gap >= N2 + 3) begin
         m_valid = 1'b0;
         chk("R6 timeout valid", frame_valid, 0);
         chk("R6 timeout rate kept", frame_rate, m_rate);
      end
      chk("R9 no stb between edges", frame_stb, 0);
      last_gap = gap;
   endtask

   function automatic string tag_for(input int gap);
      if (gap == N8) return "R3";
      if (gap == N2) return "R4";
      return "R5";
   endfunction

   initial begin
      int stb_cnt;
      do_reset(1'b0);
      // R2: first edge after reset is not judged even with a nominal gap before it
      repeat (N8 - 1) @(negedge clk);
      frame(N8, "R2 first edge");
      frame(N8, "R3 8k");
      frame(N8, "R3 8k repeat");
      frame(N2, "R3 8k before 2k");
      frame(N2, "R4 2k");
      frame(N8 + 1, "R4 2k then long");
      frame(N8 - 1, "R5 reject +1");
      frame(N8, "R5 reject -1");
      frame(N2 - 1, "R7 recover 8k");
      frame(N2 + 1, "R5 reject 2k-1");
      frame(N2 + 2, "R5 reject 2k+1");
      frame(N2 + 9, "R5 reject 2k+2");
      frame(N2, "R6 after timeout");
      frame(N8, "R7 recover 2k");
      // R2: a sync held active produces only one edge
      drive_level(1'b1);
      repeat (3) @(negedge clk);
      stb_cnt = 0;
      repeat (N8 * 2) begin
         @(negedge clk);
         stb_cnt += frame_stb;
      end
      chk("R2 held sync no edges", stb_cnt, 0);
      drive_level(1'b0);
      // constrained random periods
      do_reset(1'b0);
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < 120; i++) begin
         int sel, gap;
         sel = $urandom_range(0, 9);
         case (sel)
            0, 1, 2: gap = N8;
            3, 4:    gap = N2;
            5:       gap = N8 + (($urandom_range(0, 1) == 1) ? 1 : -1);
            6:       gap = N2 + (($urandom_range(0, 1) == 1) ? 1 : -1);
            7:       gap = N2 + $urandom_range(2, 12);
            default: gap = $urandom_range(3, N2 + 4);
         endcase
         frame(gap, tag_for(last_gap));
      end
      frame(N8, "R9 tail");
      // R8: active-low input
      do_reset(1'b1);
      frame(N8, "R8 first");
      frame(N2, "R8 8k");
      frame(N8, "R8 2k");
      frame(N8 + 2, "R8 8k again");
      frame(N8, "R8 reject");
      frame(N8, "R8 recover");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule